// File: doc/BRIEF.md
# Receive Queue Interrupt Generator

This block sits between a serial receiver's deserializer and the CPU. Each received byte arrives with its own error indications. The byte and those indications are placed in a four-entry queue. The CPU sees the oldest byte on a read port and removes it with a pop strobe. A status word shows the error indications of the oldest byte, together with any indications that have been latched earlier.

The block drives two interrupt requests:

- The data request fires at a level chosen by a configuration bit: either as soon as one byte is waiting, or only once four bytes are waiting.
- The special request fires when the status word carries an overrun, a CRC or framing error, or an end-of-frame mark. A parity error also raises it, but only when a separate enable bit allows this.

Latched status bits stay set until the CPU issues an error-reset strobe, even after the byte that caused them has been popped. When a byte arrives while the queue is full and nothing is popped, that byte replaces the newest entry and the entry is marked as overrun.

Top module: `rx_intr_fifo`

## Requirements
- R1: After reset the queue is empty, `rd_data` is zero, `stat_flags` is zero, and both `irq_data` and `irq_special` are low.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest byte, or zero when the queue is empty. `rd_pop` removes the oldest entry at the clock edge, and a pop of an empty queue has no effect.
- R3: With `cfg_quad` low, `irq_data` is high in every cycle in which at least one byte is queued, starting the cycle after the edge that stored the byte.
- R4: With `cfg_quad` high, `irq_data` is high only while four bytes are queued.
- R5: `irq_data` falls in the same cycle in which the occupancy, updated at a pop edge, drops below the selected level, with no extra register delay.
- R6: A byte accepted while four entries are queued and `rd_pop` is low overwrites the newest entry and sets that entry's overrun bit. The occupancy stays at four and the three older bytes are unchanged. A pop in the same cycle makes room, so the byte is queued normally.
- R7: `stat_flags` bit 0 is overrun, bit 1 is CRC or framing error, bit 2 is end of frame and bit 3 is parity error. The bits of the oldest queued entry show in `stat_flags` while that entry is at the head.
- R8: Once a status bit has been shown for a head entry, it stays set in `stat_flags` until an `err_reset` edge clears it, even after that entry is popped.
- R9: `irq_special` equals the OR of `stat_flags` bits 0, 1 and 2, ORed with bit 3 when `cfg_par_sc` is high.
- R10: The parity bit of `stat_flags` is reported whether or not `cfg_par_sc` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_data | input | 8 | Received byte |
| in_crc_err | input | 1 | CRC or framing error on this byte |
| in_eof | input | 1 | This byte ends a frame |
| in_par_err | input | 1 | Parity error on this byte |
| cfg_quad | input | 1 | 0: data request at one byte, 1: at four bytes |
| cfg_par_sc | input | 1 | Parity error counts as a special condition |
| rd_pop | input | 1 | CPU removes the oldest byte |
| err_reset | input | 1 | CPU clears the latched status bits |
| rd_data | output | 8 | Oldest queued byte, zero when empty |
| stat_flags | output | 4 | Status word: {parity, end of frame, CRC/framing, overrun} |
| irq_data | output | 1 | Data-available interrupt request |
| irq_special | output | 1 | Special-condition interrupt request |

## Verification
The hardest state to reach is an overrun mark on an entry that has not yet reached the head. It appears at the ports only after the three older bytes have been popped, and only while the latch has not been cleared since. The stimulus runs random phases in which writes strongly outnumber pops, so the queue stays full for long stretches. A directed sequence also fills the queue, overwrites the newest entry, and then pops down to it. The bench model tracks each entry's flags and the latched status on every cycle, so a lost or misplaced overrun bit shows up at the moment the entry reaches the head.

// File: rtl/rx_intr_pkg.sv
package rx_intr_pkg;
   // status bit order: [3] parity, [2] end of frame, [1] crc/framing, [0] overrun
   typedef struct packed {
      logic par;
      logic eof;
      logic crc;
      logic ovr;
   } rx_flag_t;

   localparam int FLAG_W = $bits(rx_flag_t);
endpackage

// File: rtl/rx_intr_store.sv
module rx_intr_store
   import rx_intr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  rx_flag_t          in_flags,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output rx_flag_t          head_flags,
   output logic              empty,
   output logic              full,
   output logic [CNT_W-1:0]  count
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rx_intr_store: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] dmem [DEPTH];
   rx_flag_t          fmem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr, wr_idx;
   logic [CNT_W-1:0]  cnt;
   logic              pop_eff, push, ovw;
   rx_flag_t          wr_flags;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign pop_eff = pop && !empty;
   assign push    = in_valid && (!full || pop_eff);
   assign ovw     = in_valid && full && !pop_eff;
   assign wr_idx  = ovw ? PTR_W'(wr_ptr - 1'b1) : wr_ptr;

   always_comb begin
      wr_flags     = in_flags;
      wr_flags.ovr = ovw;
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dmem[i] <= '0;
               fmem[i] <= '0;
            end else if ((push || ovw) && wr_idx == PTR_W'(i)) begin
               dmem[i] <= in_data;
               fmem[i] <= wr_flags;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (pop_eff) rd_ptr <= rd_ptr + 1'b1;
         if (push)    wr_ptr <= wr_ptr + 1'b1;
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop_eff);
      end
   end

   assign head_data  = empty ? '0 : dmem[rd_ptr];
   assign head_flags = empty ? '0 : fmem[rd_ptr];
   assign count      = cnt;

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   // R6
   ovw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && full && !pop) |=> (cnt == CNT_W'(DEPTH)));
   // R2
   empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (head_data == '0));
endmodule

// File: rtl/rx_intr_level.sv
module rx_intr_level #(
   parameter int DEPTH      = 4,
   parameter int QUAD_LEVEL = 4,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0] count,
   input  logic             cfg_quad,
   output logic             irq_data
);
   generate
      if (QUAD_LEVEL < 1 || QUAD_LEVEL > DEPTH) begin : g_bad_level
         $error("rx_intr_level: QUAD_LEVEL must lie between 1 and DEPTH");
      end
   endgenerate

   logic [CNT_W-1:0] level;
   assign level    = cfg_quad ? CNT_W'(QUAD_LEVEL) : CNT_W'(1);
   assign irq_data = (count >= level);
endmodule

// File: rtl/rx_intr_flags.sv
module rx_intr_flags
   import rx_intr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  rx_flag_t head_flags,
   input  logic     err_reset,
   input  logic     cfg_par_sc,
   output rx_flag_t stat,
   output logic     irq_special
);
   rx_flag_t held;

   always_ff @(posedge clk) begin
      if (!rst_n)         held <= '0;
      else if (err_reset) held <= '0;
      else                held <= held | head_flags;
   end

   assign stat        = held | head_flags;
   assign irq_special = stat.ovr || stat.crc || stat.eof || (stat.par && cfg_par_sc);

   // R8
   held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !err_reset |=> ((held & $past(held)) == $past(held)));
   // R9
   par_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_par_sc && !stat.ovr && !stat.crc && !stat.eof) |-> !irq_special);
endmodule

// File: rtl/rx_intr_fifo.sv
module rx_intr_fifo
   import rx_intr_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 4,
   parameter int QUAD_LEVEL = 4,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_crc_err,
   input  logic              in_eof,
   input  logic              in_par_err,
   input  logic              cfg_quad,
   input  logic              cfg_par_sc,
   input  logic              rd_pop,
   input  logic              err_reset,
   output logic [DATA_W-1:0] rd_data,
   output logic [FLAG_W-1:0] stat_flags,
   output logic              irq_data,
   output logic              irq_special
);
   rx_flag_t         in_flags, head_flags, stat;
   logic             empty, full;
   logic [CNT_W-1:0] count;

   always_comb begin
      in_flags     = '0;
      in_flags.crc = in_crc_err;
      in_flags.eof = in_eof;
      in_flags.par = in_par_err;
   end

   rx_intr_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_flags(in_flags), .pop(rd_pop), .head_data(rd_data),
      .head_flags(head_flags), .empty(empty), .full(full), .count(count)
   );

   rx_intr_level #(.DEPTH(DEPTH), .QUAD_LEVEL(QUAD_LEVEL)) u_level (
      .count(count), .cfg_quad(cfg_quad), .irq_data(irq_data)
   );

   rx_intr_flags u_flags (
      .clk(clk), .rst_n(rst_n), .head_flags(head_flags), .err_reset(err_reset),
      .cfg_par_sc(cfg_par_sc), .stat(stat), .irq_special(irq_special)
   );

   assign stat_flags = stat;

   // R3
   data_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_quad && !empty) |-> irq_data);
   // R4
   data_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_quad && irq_data) |-> (QUAD_LEVEL < DEPTH || full));
   // R7
   head_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & head_flags) == head_flags));
endmodule

// File: tb/rx_intr_fifo_test.sv
module rx_intr_fifo_test;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_crc_err = 1'b0, in_eof = 1'b0, in_par_err = 1'b0;
   logic [7:0] in_data = '0;
   logic cfg_quad = 1'b0, cfg_par_sc = 1'b0, rd_pop = 1'b0, err_reset = 1'b0;
   logic [7:0] rd_data;
   logic [3:0] stat_flags;
   logic irq_data, irq_special;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] mq_d [DEPTH];
   logic [3:0] mq_f [DEPTH];
   int         mcnt = 0;
   logic [3:0] mheld = '0;

   always #5 clk = ~clk;

   rx_intr_fifo uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_crc_err(in_crc_err), .in_eof(in_eof), .in_par_err(in_par_err),
      .cfg_quad(cfg_quad), .cfg_par_sc(cfg_par_sc), .rd_pop(rd_pop),
      .err_reset(err_reset), .rd_data(rd_data), .stat_flags(stat_flags),
      .irq_data(irq_data), .irq_special(irq_special)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_stat();
      return mheld | ((mcnt > 0) ? mq_f[0] : 4'b0);
   endfunction

   function automatic logic exp_data_irq();
      return cfg_quad ? (mcnt >= DEPTH) : (mcnt >= 1);
   endfunction

   function automatic logic exp_special();
      logic [3:0] s = exp_stat();
      return (|s[2:0]) || (s[3] && cfg_par_sc);
   endfunction

   task automatic model_update(input logic v, input logic [7:0] d, input logic crc,
                               input logic eof, input logic par, input logic p, input logic e);
      logic [3:0] hf = (mcnt > 0) ? mq_f[0] : 4'b0;
      mheld = e ? 4'b0 : (mheld | hf);
      if (p && mcnt > 0) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            mq_d[i] = mq_d[i+1];
            mq_f[i] = mq_f[i+1];
         end
         mcnt--;
      end
      if (v) begin
         if (mcnt < DEPTH) begin
            mq_d[mcnt] = d;
            mq_f[mcnt] = {par, eof, crc, 1'b0};
            mcnt++;
         end else begin
            mq_d[DEPTH-1] = d;
            mq_f[DEPTH-1] = {par, eof, crc, 1'b1};
         end
      end
   endtask

   task automatic compare_all();
      chk("R2 rd_data", rd_data, (mcnt > 0) ? mq_d[0] : 8'h00);
      chk("R8 stat_flags", stat_flags, exp_stat());
      chk(cfg_quad ? "R4 irq_data" : "R3 irq_data", irq_data, exp_data_irq());
      chk("R9 irq_special", irq_special, exp_special());
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic step(input logic v, input logic [7:0] d, input logic crc,
                       input logic eof, input logic par, input logic p, input logic e);
      in_valid = v; in_data = d; in_crc_err = crc; in_eof = eof; in_par_err = par;
      rd_pop = p; err_reset = e;
      @(posedge clk);
      model_update(v, d, crc, eof, par, p, e);
      @(negedge clk);
      in_valid = 1'b0; in_crc_err = 1'b0; in_eof = 1'b0; in_par_err = 1'b0;
      rd_pop = 1'b0; err_reset = 1'b0;
      #1;
      compare_all();
   endtask

   initial begin
      int dummy;
      dummy = $urandom(32'h5eed_1234);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 stat_flags", stat_flags, 4'h0);
      chk("R1 irq_data", irq_data, 1'b0);
      chk("R1 irq_special", irq_special, 1'b0);

      // R2 pop of empty queue ignored
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R2 empty pop", rd_data, 8'h00);

      // R4 four-byte level
      cfg_quad = 1'b1;
      for (int i = 1; i <= 3; i++) step(1'b1, 8'(i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R4 three queued", irq_data, 1'b0);
      step(1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R4 four queued", irq_data, 1'b1);

      // R6 overrun replaces newest entry
      step(1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6 count held", irq_data, 1'b1);
      chk("R6 head unchanged", rd_data, 8'h01);

      // R5 drop below level after pop
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R5 irq_data fall", irq_data, 1'b0);
      chk("R2 second byte", rd_data, 8'h02);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R6 new byte at head", rd_data, 8'hAA);
      chk("R6 overrun bit", stat_flags, 4'b0001);
      chk("R7 overrun special", irq_special, 1'b1);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R8 held after pop", stat_flags, 4'b0001);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R8 cleared", stat_flags, 4'b0000);

      // R10 parity shown but masked
      cfg_quad = 1'b0;
      cfg_par_sc = 1'b0;
      step(1'b1, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R10 parity bit", stat_flags, 4'b1000);
      chk("R9 parity masked", irq_special, 1'b0);
      chk("R3 one byte", irq_data, 1'b1);
      cfg_par_sc = 1'b1;
      #1;
      chk("R9 parity enabled", irq_special, 1'b1);
      // R7 crc and eof positions
      step(1'b1, 8'h66, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      chk("R7 crc eof bits", stat_flags, 4'b1110);
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R5 empty irq_data", irq_data, 1'b0);

      // random phases
      for (int ph = 0; ph < 8; ph++) begin
         int pv = ph[0] ? 30 : 75;
         int pp = ph[0] ? 65 : 20;
         for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 19) == 0) begin
               cfg_quad   = 1'($urandom_range(0, 1));
               cfg_par_sc = 1'($urandom_range(0, 1));
               #1;
               compare_all();
            end
            step(($urandom_range(0, 99) < pv), 8'($urandom),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 99) < pp),
                 ($urandom_range(0, 15) == 0));
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule